// File: doc/BRIEF.md
# Logical Port to Identifier Mapper

This block translates the 8-bit logical port number carried by each ingress data word into a 6-bit logical identifier. The translation comes from a table with one entry for each possible port. Each entry holds the identifier, an enable flag and a flag that reverses the bit order. Software programs entries through a simple write strobe. Each write is screened in a single cycle against two rules: at most 64 entries may be enabled, and no two enabled entries may share an identifier. An offending write leaves the table untouched and returns an error code.

On the data side, a word whose port is enabled leaves one cycle later, tagged with its identifier and with each byte bit-reversed if the entry asks for it. A word for a disabled port is discarded, and a one-cycle inactive-port pulse is raised. A separate status query port answers, for any port number, whether that port can take data. Disabled ports always report as available. Enabled ports report the availability that the downstream logic gives for their identifier.

Top module: `lp_id_mapper`

## Requirements
- R1: After reset every entry reads as zero. Every port is therefore disabled: data on any port is dropped, every status query answers available, and no write response or output word is pending.
- R2: A written entry byte holds the identifier in bits 5:0, the enable flag in bit 6 and the reversal flag in bit 7. For example, 0x45 written to entry 8 maps port 8 to identifier 5, enabled, without reversal.
- R3: Every write strobe produces exactly one response, with valid high in the cycle after the strobe. Code 0 means the write was accepted and the entry takes the new value. Codes 1 and 2 are errors, and code 3 is never produced.
- R4: A write that would enable an entry while 64 other entries are already enabled returns code 1 and leaves the table unchanged. This check takes precedence over the duplicate check.
- R5: A write that enables an entry with an identifier already held by a different enabled entry returns code 2 and leaves the table unchanged.
- R6: Rewriting an enabled entry with its own current identifier is accepted, even when 64 entries are enabled, and does not raise the enabled count.
- R7: Writing an entry with its enable bit clear is always accepted. It frees both the entry's identifier and its place under the limit.
- R8: A valid input word on an enabled port appears one cycle later on the output, with out_vld high, the entry's identifier, and the start and end markers and data unchanged. The lookup uses the table as it stood before any write in the same cycle.
- R9: A valid input word on a disabled port produces no output word. Instead, drop_evt pulses high for exactly that one following cycle. Without a valid input, both out_vld and drop_evt are low.
- R10: When the entry's reversal flag is set, each of the four data bytes is output with its bits reversed (bit 7 of the byte exchanged with bit 0, 6 with 1, and so on).
- R11: stat_avail, one cycle after stat_port is presented, is 1 for a disabled port. For an enabled port it is bit <identifier> of id_avail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Entry write strobe |
| cfg_addr | input | 8 | Entry index (logical port) to write |
| cfg_wdata | input | 8 | Entry value: identifier, enable, reversal |
| cfg_rsp_vld | output | 1 | Write response valid |
| cfg_rsp_code | output | 2 | 0 accepted, 1 limit exceeded, 2 duplicate identifier |
| in_vld | input | 1 | Input word valid |
| in_port | input | 8 | Logical port of the input word |
| in_data | input | 32 | Input data word |
| in_sop | input | 1 | Start-of-packet marker |
| in_eop | input | 1 | End-of-packet marker |
| out_vld | output | 1 | Output word valid |
| out_id | output | 6 | Identifier of the output word |
| out_data | output | 32 | Output data, reversed per byte if requested |
| out_sop | output | 1 | Start-of-packet marker |
| out_eop | output | 1 | End-of-packet marker |
| drop_evt | output | 1 | Inactive-port event pulse |
| stat_port | input | 8 | Port whose availability is queried |
| id_avail | input | 64 | Downstream availability, one bit per identifier |
| stat_avail | output | 1 | Availability answer for stat_port |

## Verification
Every result of this block is due exactly one clock after its cause. The write response, the tagged or dropped data word and the status answer each pass through a single register stage. The bench drives inputs on the falling edge and predicts each result from a behavioural model of the table, using the table as it stood before that cycle's write. It compares every output on the next falling edge. The bench therefore never waits a variable time: a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [1:0] {
      RSP_OK   = 2'd0,
      RSP_FULL = 2'd1,
      RSP_DUP  = 2'd2
   } rsp_e;

endpackage

// File: rtl/lpm_table.sv
module lpm_table #(
   parameter int PORT_W = 8,
   parameter int ID_W   = 6,
   parameter int MAX_EN = 64,
   localparam int EW    = ID_W + 2,
   localparam int NID   = 1 << ID_W,
   localparam int CNT_W = $clog2(MAX_EN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PORT_W-1:0] waddr,
   input  logic [EW-1:0]     wdata,
   input  logic [PORT_W-1:0] lk_port,
   input  logic [PORT_W-1:0] st_port,
   output logic              rsp_vld,
   output logic [1:0]        rsp_code,
   output logic [EW-1:0]     lk_ent,
   output logic [EW-1:0]     st_ent,
   output logic [CNT_W-1:0]  en_count,
   output logic [NID-1:0]    occ
);
   import lpm_pkg::*;

   localparam int DEPTH = 1 << PORT_W;
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_EN);

   if (MAX_EN > NID) begin : g_cap_chk
      $error("MAX_EN exceeds the number of identifiers");
   end

   logic [EW-1:0] tab [DEPTH];

   logic [EW-1:0]   old_ent;
   logic            o_en, n_en, own_id, full, dup;
   logic [ID_W-1:0] o_id, n_id;
   rsp_e            code;

   always_comb begin
      old_ent = tab[waddr];
      o_en    = old_ent[ID_W];
      o_id    = old_ent[ID_W-1:0];
      n_en    = wdata[ID_W];
      n_id    = wdata[ID_W-1:0];
      own_id  = o_en && (o_id == n_id);
      full    = n_en && !o_en && (en_count == CAP);
      dup     = n_en && occ[n_id] && !own_id;
      if (full)     code = RSP_FULL;
      else if (dup) code = RSP_DUP;
      else          code = RSP_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
         occ      <= '0;
         en_count <= '0;
         rsp_vld  <= 1'b0;
         rsp_code <= RSP_OK;
      end else begin
         rsp_vld <= wr;
         if (wr) begin
            rsp_code <= code;
            if (code == RSP_OK) begin
               tab[waddr] <= wdata;
               if (o_en && !n_en)      en_count <= en_count - 1'b1;
               else if (!o_en && n_en) en_count <= en_count + 1'b1;
               for (int k = 0; k < NID; k++) begin
                  if (n_en && (n_id == ID_W'(k)))      occ[k] <= 1'b1;
                  else if (o_en && (o_id == ID_W'(k))) occ[k] <= 1'b0;
               end
            end
         end
      end
   end

   assign lk_ent = tab[lk_port];
   assign st_ent = tab[st_port];

endmodule

// File: rtl/lpm_path.sv
module lpm_path #(
   parameter int ID_W    = 6,
   parameter int DATA_W  = 32,
   parameter bit REV_SUP = 1'b1,
   localparam int EW     = ID_W + 2,
   localparam int NB     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [EW-1:0]     ent,
   output logic              out_vld,
   output logic [ID_W-1:0]   out_id,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              drop_evt
);
   if (DATA_W % 8 != 0) begin : g_w_chk
      $error("DATA_W must be a whole number of bytes");
   end

   logic [DATA_W-1:0] rev_data;
   logic [DATA_W-1:0] sel_data;

   if (REV_SUP) begin : g_rev
      for (genvar b = 0; b < NB; b++) begin : g_byte
         for (genvar i = 0; i < 8; i++) begin : g_bit
            assign rev_data[8*b+i] = in_data[8*b+7-i];
         end
      end
      assign sel_data = ent[ID_W+1] ? rev_data : in_data;
   end else begin : g_norev
      assign rev_data = in_data;
      assign sel_data = rev_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         drop_evt <= 1'b0;
         out_id   <= '0;
         out_data <= '0;
         out_sop  <= 1'b0;
         out_eop  <= 1'b0;
      end else begin
         out_vld  <= in_vld && ent[ID_W];
         drop_evt <= in_vld && !ent[ID_W];
         out_id   <= ent[ID_W-1:0];
         out_data <= sel_data;
         out_sop  <= in_sop;
         out_eop  <= in_eop;
      end
   end

endmodule

// File: rtl/lpm_status.sv
module lpm_status #(
   parameter int ID_W = 6,
   localparam int NID = 1 << ID_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            st_en,
   input  logic [ID_W-1:0] st_id,
   input  logic [NID-1:0]  id_avail,
   output logic            stat_avail
);
   always_ff @(posedge clk) begin
      if (!rst_n) stat_avail <= 1'b1;
      else        stat_avail <= st_en ? id_avail[st_id] : 1'b1;
   end

endmodule

// File: rtl/lp_id_mapper.sv
module lp_id_mapper #(
   parameter int PORT_W  = 8,
   parameter int ID_W    = 6,
   parameter int MAX_EN  = 64,
   parameter int DATA_W  = 32,
   parameter bit REV_SUP = 1'b1,
   localparam int NID    = 1 << ID_W,
   localparam int EW     = ID_W + 2,
   localparam int CNT_W  = $clog2(MAX_EN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [PORT_W-1:0] cfg_addr,
   input  logic [EW-1:0]     cfg_wdata,
   output logic              cfg_rsp_vld,
   output logic [1:0]        cfg_rsp_code,
   input  logic              in_vld,
   input  logic [PORT_W-1:0] in_port,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_vld,
   output logic [ID_W-1:0]   out_id,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              drop_evt,
   input  logic [PORT_W-1:0] stat_port,
   input  logic [NID-1:0]    id_avail,
   output logic              stat_avail
);
   logic [EW-1:0]    lk_ent, st_ent;
   logic [CNT_W-1:0] en_count;
   logic [NID-1:0]   occ;

   lpm_table #(.PORT_W(PORT_W), .ID_W(ID_W), .MAX_EN(MAX_EN)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .waddr    (cfg_addr),
      .wdata    (cfg_wdata),
      .lk_port  (in_port),
      .st_port  (stat_port),
      .rsp_vld  (cfg_rsp_vld),
      .rsp_code (cfg_rsp_code),
      .lk_ent   (lk_ent),
      .st_ent   (st_ent),
      .en_count (en_count),
      .occ      (occ)
   );

   lpm_path #(.ID_W(ID_W), .DATA_W(DATA_W), .REV_SUP(REV_SUP)) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_data  (in_data),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .ent      (lk_ent),
      .out_vld  (out_vld),
      .out_id   (out_id),
      .out_data (out_data),
      .out_sop  (out_sop),
      .out_eop  (out_eop),
      .drop_evt (drop_evt)
   );

   lpm_status #(.ID_W(ID_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_en      (st_ent[ID_W]),
      .st_id      (st_ent[ID_W-1:0]),
      .id_avail   (id_avail),
      .stat_avail (stat_avail)
   );

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
   parameter int ID_W   = 6,
   parameter int MAX_EN = 64,
   parameter int CNT_W  = 7,
   localparam int NID   = 1 << ID_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic             cfg_rsp_vld,
   input logic [1:0]       cfg_rsp_code,
   input logic             in_vld,
   input logic             out_vld,
   input logic             drop_evt,
   input logic [CNT_W-1:0] en_count,
   input logic [NID-1:0]   occ
);
   p_rsp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> cfg_rsp_vld);
   p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> !cfg_rsp_vld);
   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rsp_vld |-> cfg_rsp_code != 2'd3);
   p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_count <= CNT_W'(MAX_EN));
   p_reject_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rsp_vld && cfg_rsp_code != 2'd0) |-> $stable(en_count));
   p_occ_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(occ) == int'(en_count));
   p_word_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (out_vld || drop_evt));
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && !drop_evt));
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_vld && drop_evt));
endmodule

bind lp_id_mapper lpm_checker #(.ID_W(ID_W), .MAX_EN(MAX_EN), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr       (cfg_wr),
   .cfg_rsp_vld  (cfg_rsp_vld),
   .cfg_rsp_code (cfg_rsp_code),
   .in_vld       (in_vld),
   .out_vld      (out_vld),
   .drop_evt     (drop_evt),
   .en_count     (en_count),
   .occ          (occ)
);

// File: tb/sim_lp_id_mapper.sv
`timescale 1ns/1ps
module sim_lp_id_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        cfg_rsp_vld;
   logic [1:0]  cfg_rsp_code;
   logic        in_vld = 1'b0;
   logic [7:0]  in_port = '0;
   logic [31:0] in_data = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic        out_vld;
   logic [5:0]  out_id;
   logic [31:0] out_data;
   logic        out_sop;
   logic        out_eop;
   logic        drop_evt;
   logic [7:0]  stat_port = '0;
   logic [63:0] id_avail = '0;
   logic        stat_avail;

   always #10 clk = ~clk;

   lp_id_mapper u0 (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [7:0] ref_tab [256];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rev_bytes(input logic [31:0] d);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         for (int i = 0; i < 8; i++) r[8*b+i] = d[8*b+7-i];
      return r;
   endfunction

   function automatic int ref_write(input int a, input logic [7:0] w);
      int cnt = 0;
      for (int j = 0; j < 256; j++) if (ref_tab[j][6]) cnt++;
      if (w[6] && !ref_tab[a][6] && cnt >= 64) return 1;
      if (w[6])
         for (int j = 0; j < 256; j++)
            if (j != a && ref_tab[j][6] && ref_tab[j][5:0] == w[5:0]) return 2;
      ref_tab[a] = w;
      return 0;
   endfunction

   task automatic cyc();
      logic [7:0] le, se;
      bit e_vld, e_drop, e_sa, e_rv;
      int e_code;
      logic [31:0] e_data;
      le = ref_tab[in_port];
      se = ref_tab[stat_port];
      e_vld  = in_vld && le[6];
      e_drop = in_vld && !le[6];
      e_data = le[7] ? rev_bytes(in_data) : in_data;
      e_sa   = se[6] ? id_avail[se[5:0]] : 1'b1;
      e_rv   = cfg_wr;
      e_code = cfg_wr ? ref_write(int'(cfg_addr), cfg_wdata) : 0;
      @(posedge clk);
      @(negedge clk);
      if (done) return;
      chk(cfg_rsp_vld == e_rv, "R3 rsp_vld", cfg_rsp_vld, e_rv);
      if (e_rv)
         chk(cfg_rsp_code == e_code[1:0],
             e_code == 1 ? "R4 code" : e_code == 2 ? "R5 code" : "R3 code",
             cfg_rsp_code, e_code);
      chk(out_vld == e_vld, "R8 out_vld", out_vld, e_vld);
      chk(drop_evt == e_drop, "R9 drop_evt", drop_evt, e_drop);
      if (e_vld) begin
         chk(out_id == le[5:0], "R8 out_id", out_id, le[5:0]);
         chk(out_data == e_data, le[7] ? "R10 out_data" : "R8 out_data", out_data, e_data);
         chk({out_sop, out_eop} == {in_sop, in_eop}, "R8 markers", {out_sop, out_eop}, {in_sop, in_eop});
      end
      chk(stat_avail == e_sa, "R11 stat_avail", stat_avail, e_sa);
   endtask

   task automatic wr_ent(input int a, input logic [7:0] w);
      cfg_wr = 1'b1; cfg_addr = a[7:0]; cfg_wdata = w;
      cyc();
      cfg_wr = 1'b0;
   endtask

   task automatic send(input int p, input logic [31:0] d);
      in_vld = 1'b1; in_port = p[7:0]; in_data = d; in_sop = 1'b1; in_eop = 1'b1;
      stat_port = p[7:0];
      cyc();
      in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int k;
      for (int i = 0; i < 256; i++) ref_tab[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: nothing pending after reset, all ports disabled and available
      chk(!cfg_rsp_vld && !out_vld && !drop_evt, "R1 idle outputs",
          {cfg_rsp_vld, out_vld, drop_evt}, 0);
      chk(stat_avail == 1'b1, "R1 stat_avail", stat_avail, 1);
      send(8, 32'h1234_5678);          // R1/R9 disabled port drops
      // R2: 0x45 to entry 8 -> port 8 id 5 enabled, no reversal
      wr_ent(8, 8'h45);
      send(8, 32'hA5C3_0F81);
      // R5: id 5 already held by port 8
      wr_ent(9, 8'h45);
      send(9, 32'h0000_00FF);
      // R6: own id rewrite accepted
      wr_ent(8, 8'h45);
      // R10: reversal on port 10, id 7
      wr_ent(10, 8'hC7);
      send(10, 32'h0102_80F0);
      // fill to 64 enabled entries (R4)
      k = 100;
      for (int id = 0; id < 64; id++) begin
         if (id != 5 && id != 7) begin
            wr_ent(k, 8'h40 | id[7:0]);
            k++;
         end
      end
      wr_ent(200, 8'h45);              // R4 precedence over duplicate
      wr_ent(201, 8'h40);              // R4 limit
      send(201, 32'hDEAD_BEEF);
      wr_ent(8, 8'h45);                // R6 at limit, no double count
      wr_ent(10, 8'h07);               // R7 disable frees slot and id
      wr_ent(200, 8'h47);              // R7 reuse freed id 7
      send(200, 32'h1111_2222);
      wr_ent(201, 8'h41);              // R4 still full again
      // R11: enabled port availability follows id_avail
      id_avail = 64'h0000_0000_0000_0080;
      send(200, 32'h3);
      id_avail = 64'h0;
      send(200, 32'h4);
      send(10, 32'h5);                 // R11 disabled port available
      // mixed traffic with writes on low ports (R3..R11)
      for (int i = 0; i < 3000; i++) begin
         cfg_wr    = ($urandom_range(0, 5) == 0);
         cfg_addr  = 8'($urandom_range(0, 15));
         cfg_wdata = 8'($urandom_range(0, 255)) & 8'hCF;
         in_vld    = $urandom_range(0, 1);
         in_port   = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(100, 163))
                                                 : 8'($urandom_range(0, 15));
         in_data   = $urandom;
         in_sop    = $urandom_range(0, 1);
         in_eop    = $urandom_range(0, 1);
         stat_port = 8'($urandom_range(0, 255));
         id_avail  = {$urandom, $urandom};
         cyc();
      end
      cfg_wr = 1'b0; in_vld = 1'b0;
      cyc();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule